// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is a single-target SPI master. Software reaches it through a small 32-bit register file on a simple select/write bus. One register holds the chip-select level. One register holds the transfer setup: clock polarity, clock phase, 8- or 16-bit words, and a 5-bit clock-rate code. Writing a word to the transmit register launches one full-duplex exchange. When the last bit has been clocked, the received word is placed in the receive register and a completion flag is raised. Software polls the flag and clears it by writing zero to it.

Inside the block there are three parts. The bus register file sits in the top module. A half-period tick generator sets the serial clock rate. A shift-engine state machine has three states: `ST_IDLE` (waiting), `ST_LEAD` (the next serial-clock edge is the leading one) and `ST_TRAIL` (the next edge is the trailing one). Its transitions are:
- START: from `ST_IDLE` to `ST_LEAD` on an accepted transmit write.
- LEAD_EDGE: from `ST_LEAD` to `ST_TRAIL` on a tick.
- NEXT_BIT: from `ST_TRAIL` to `ST_LEAD` on a tick while bits remain.
- FINISH: from `ST_TRAIL` to `ST_IDLE` on the tick of the final trailing edge.

The rate code is 16 plus N, which gives a serial clock period of 2N system clocks. The usable divisors are therefore the even values from 4 to 30.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, every register reads zero. The select output `spi_ss_n` is 1 (inactive), `spi_sclk` is 0, and 8-bit mode 0 is in effect.
- R2: Bit 0 of the control register (offset 0x00) sets the chip select. Writing 1 drives `spi_ss_n` low and writing 0 drives it high. The bit reads back.
- R3: The setup register (offset 0x04) holds CPHA at bit 12, CPOL at bit 11, word width at bit 5 (1 selects 16 bits, 0 selects 8 bits) and the rate code at bits [4:0]. All other bits read zero.
- R4: A rate code of 0x10+N with N from 2 to 15 gives a serial clock half-period of N clocks. The completion flag is set exactly 2·B·N clock edges after the edge that accepted the transmit write, where B is 8 or 16.
- R5: A code with bit 4 clear, or a code of 0x10 or 0x11, behaves as N=2. The serial clock never runs faster than one quarter of the system clock.
- R6: Data moves most significant bit first in all four CPOL/CPHA modes, and the serial clock idles at the configured CPOL level. With CPHA=0, MOSI is valid before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges. In 8-bit mode, only bits [7:0] of the transmit write are sent.
- R7: After completion, the receive register (offset 0x0C) holds the received word in its low 8 or 16 bits. Its upper bits read zero.
- R8: Bit 0 of the cause register (offset 0x10) reads 1 once an exchange completes. A write of 0x00000000 clears it. A write of any nonzero value leaves it unchanged.
- R9: A write to the transmit register (offset 0x08) while an exchange is running is ignored. The timing and the data of the running exchange are unchanged.
- R10: A write to the setup register during an exchange has no effect on that exchange. The new setup applies from the next start.
- R11: The transmit register and all undefined offsets (for example 0x14 and 0x02) read zero, and reading them has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_ss_n | output | 1 | Active-low chip select |

## Verification
Some properties are checked by assertions on every cycle. Tick pulses never come on consecutive clocks, so the serial clock is never faster than a quarter of the system rate. The latched setup stays frozen while an exchange runs. A transmit write during an exchange leaves the shift register untouched. The completion flag rises only on the engine's finish pulse, and a zero write clears it. Other properties can only be shown by the bench's scenarios, because they depend on what a target on the wire sees. These are bit order and edge placement in all four modes, the exact cycle count for each divisor, the clamping of low codes, the contents of the receive register, and the register read-back and decode.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 5;
    localparam int SHIFT_W   = 16;
    localparam int CODE_W    = 5;
    localparam int HALF_W    = 4;
    localparam int MIN_HALF  = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_SETUP = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_TX    = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_RX    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 5'h10;

    localparam int BIT_CPHA = 12;
    localparam int BIT_CPOL = 11;
    localparam int BIT_WIDE = 5;

    typedef struct packed {
        logic              cpha;
        logic              cpol;
        logic              wide;
        logic [CODE_W-1:0] code;
    } xfer_setup_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_t;

    // Half-period in system clocks; anything below the legal range is clamped.
    function automatic logic [HALF_W-1:0] half_from_code(input logic [CODE_W-1:0] c);
        if (c[CODE_W-1] && (c[HALF_W-1:0] >= HALF_W'(MIN_HALF)))
            return c[HALF_W-1:0];
        return HALF_W'(MIN_HALF);
    endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o
);
    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || cnt_q == '0)
            cnt_q <= half_i - HALF_W'(1);
        else
            cnt_q <= cnt_q - HALF_W'(1);
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_reg_pkg::*;
#(
    parameter int SHIFT_W = 16,
    parameter int HALF_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  xfer_setup_t        setup_i,
    input  logic [SHIFT_W-1:0] tx_i,
    input  logic               tick_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic [HALF_W-1:0]  half_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               done_o,
    output logic [SHIFT_W-1:0] rx_o
);
    localparam int NARROW = SHIFT_W / 2;
    localparam int CNT_W  = $clog2(SHIFT_W + 1);

    eng_state_t         state_q, state_d;
    logic               cpol_q, cpha_q;
    logic [HALF_W-1:0]  half_q;
    logic [SHIFT_W-1:0] tx_sr, rx_sr, load_word;
    logic [CNT_W-1:0]   left_q;
    logic               sclk_q, mosi_q;
    logic               start_ok, last_edge;

    assign start_ok  = start_i && (state_q == ST_IDLE);
    assign last_edge = (state_q == ST_TRAIL) && tick_i && (left_q == CNT_W'(1));
    assign load_word = setup_i.wide ? tx_i : {tx_i[NARROW-1:0], {NARROW{1'b0}}};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_LEAD;
            ST_LEAD:  if (tick_i)   state_d = ST_TRAIL;
            ST_TRAIL: if (tick_i)   state_d = (left_q == CNT_W'(1)) ? ST_IDLE : ST_LEAD;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            half_q <= HALF_W'(MIN_HALF);
            tx_sr  <= '0;
            rx_sr  <= '0;
            left_q <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_ok) begin
                    cpol_q <= setup_i.cpol;
                    cpha_q <= setup_i.cpha;
                    half_q <= half_from_code(setup_i.code);
                    sclk_q <= setup_i.cpol;
                    rx_sr  <= '0;
                    left_q <= setup_i.wide ? CNT_W'(SHIFT_W) : CNT_W'(NARROW);
                    if (!setup_i.cpha) begin
                        mosi_q <= load_word[SHIFT_W-1];
                        tx_sr  <= load_word << 1;
                    end else begin
                        mosi_q <= 1'b0;
                        tx_sr  <= load_word;
                    end
                end
                ST_LEAD: if (tick_i) begin
                    sclk_q <= ~sclk_q;
                    if (!cpha_q) begin
                        rx_sr <= {rx_sr[SHIFT_W-2:0], miso_i};
                    end else begin
                        mosi_q <= tx_sr[SHIFT_W-1];
                        tx_sr  <= tx_sr << 1;
                    end
                end
                ST_TRAIL: if (tick_i) begin
                    sclk_q <= ~sclk_q;
                    left_q <= left_q - CNT_W'(1);
                    if (cpha_q) begin
                        rx_sr <= {rx_sr[SHIFT_W-2:0], miso_i};
                    end else if (left_q != CNT_W'(1)) begin
                        mosi_q <= tx_sr[SHIFT_W-1];
                        tx_sr  <= tx_sr << 1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign half_o = busy_o ? half_q : half_from_code(setup_i.code);
    assign sclk_o = busy_o ? sclk_q : setup_i.cpol;
    assign mosi_o = mosi_q;
    assign done_o = last_edge;
    assign rx_o   = cpha_q ? {rx_sr[SHIFT_W-2:0], miso_i} : rx_sr;

    // R4
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE));
    // R10
    setup_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(half_q) && $stable(cpha_q) && $stable(cpol_q)));
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tick_i) |=> $stable(tx_sr));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ss_n
);
    logic               sel_q;
    xfer_setup_t        setup_q;
    logic [SHIFT_W-1:0] rxreg_q, eng_rx;
    logic               cause_q;
    logic               wr_en, start, busy, tick, done, clr_cause;
    logic [HALF_W-1:0]  half;
    logic [REG_W-1:0]   rd;

    assign wr_en     = bus_sel && bus_wr;
    assign start     = wr_en && (bus_addr == OFF_TX);
    assign clr_cause = wr_en && (bus_addr == OFF_CAUSE) && (bus_wdata == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            setup_q <= '0;
            rxreg_q <= '0;
            cause_q <= 1'b0;
        end else begin
            if (wr_en && bus_addr == OFF_CTRL)
                sel_q <= bus_wdata[0];
            if (wr_en && bus_addr == OFF_SETUP)
                setup_q <= '{cpha: bus_wdata[BIT_CPHA], cpol: bus_wdata[BIT_CPOL],
                             wide: bus_wdata[BIT_WIDE], code: bus_wdata[CODE_W-1:0]};
            if (done) begin
                rxreg_q <= eng_rx;
                cause_q <= 1'b1;
            end else if (clr_cause) begin
                cause_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd = '0;
        case (bus_addr)
            OFF_CTRL:  rd[0] = sel_q;
            OFF_SETUP: begin
                rd[BIT_CPHA]     = setup_q.cpha;
                rd[BIT_CPOL]     = setup_q.cpol;
                rd[BIT_WIDE]     = setup_q.wide;
                rd[CODE_W-1:0]   = setup_q.code;
            end
            OFF_RX:    rd[SHIFT_W-1:0] = rxreg_q;
            OFF_CAUSE: rd[0] = cause_q;
            default:   rd = '0;
        endcase
    end

    assign bus_rdata = bus_sel ? rd : '0;
    assign spi_ss_n  = ~sel_q;

    spi_tick_gen #(.HALF_W(HALF_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .half_i (half),
        .tick_o (tick)
    );

    spi_shift_fsm #(.SHIFT_W(SHIFT_W), .HALF_W(HALF_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .setup_i (setup_q),
        .tx_i    (bus_wdata[SHIFT_W-1:0]),
        .tick_i  (tick),
        .miso_i  (spi_miso),
        .busy_o  (busy),
        .half_o  (half),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .done_o  (done),
        .rx_o    (eng_rx)
    );

    // R8
    cause_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q) |-> $past(done));
    // R8
    cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cause && !done) |=> !cause_q);
endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_ss_n;

    int total = 0, fails = 0;
    int edge_cnt = 0, b_bits = 0, m_idx;
    logic b_cpha = 1'b0;
    logic [15:0] rx_pat = '0, cap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_master i_spi_reg_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
    );

    // Target model: shifts its pattern out MSB first on the launch edges.
    always_comb begin
        m_idx = b_cpha ? ((edge_cnt == 0) ? 0 : (edge_cnt - 1) / 2) : edge_cnt / 2;
        spi_miso = (m_idx < b_bits) ? rx_pat[b_bits - 1 - m_idx] : 1'b0;
    end

    always @(spi_sclk) begin
        if (edge_cnt < 2 * b_bits) begin
            if ((edge_cnt % 2) == int'(b_cpha)) cap = {cap[14:0], spi_mosi};
            edge_cnt = edge_cnt + 1;
        end
    end

    // {setup[15:0], tx[15:0], target pattern[15:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'h0012, 16'h12A5, 16'h003C},
        {16'h1013, 16'h005A, 16'h00C3},
        {16'h0814, 16'h0081, 16'h007E},
        {16'h183F, 16'hBEEF, 16'h1234},
        {16'h0037, 16'h8001, 16'hF00F},
        {16'h1005, 16'h0033, 16'h00CC},
        {16'h0811, 16'h770F, 16'h00F0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic int exp_half(input logic [4:0] c);
        if (c >= 5'h12) return int'(c) - 16;
        return 2;
    endfunction

    // inj: 0 none, 1 transmit write at cycle 5, 2 setup write at cycle 6
    task automatic run_xfer(input logic [15:0] tx, input int inj, output int cyc);
        bus_write(5'h08, {16'h0, tx});
        edge_cnt = 0; cap = '0; cyc = 0;
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            bus_sel = 1'b1;
            if (inj == 1 && cyc == 5) begin
                bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h0000FFFF;
            end else if (inj == 2 && cyc == 6) begin
                bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h0000183F;
            end else begin
                bus_wr = 1'b0; bus_addr = 5'h10;
            end
            #1;
            if (!bus_wr && bus_rdata[0]) break;
            @(posedge clk);
            cyc++;
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_vec(input logic [15:0] setup, input logic [15:0] tx,
                          input logic [15:0] pat, input int inj, input string tag);
        int cyc, bits, half;
        logic [31:0] d;
        logic [15:0] mask;
        bits = setup[5] ? 16 : 8;
        half = exp_half(setup[4:0]);
        mask = setup[5] ? 16'hFFFF : 16'h00FF;
        bus_write(5'h04, {16'h0, setup});
        bus_read(5'h04, d);
        check({"R3 setup readback ", tag}, d, {16'h0, setup & 16'h183F});
        b_bits = bits; b_cpha = setup[12]; rx_pat = pat & mask;
        run_xfer(tx, inj, cyc);
        check({"R4/R5 cycle count ", tag}, cyc, 2 * bits * half);
        check({"R6 mosi word ", tag}, {16'h0, cap & mask}, {16'h0, tx & mask});
        bus_read(5'h0C, d);
        check({"R7 rx register ", tag}, d, {16'h0, pat & mask});
        @(negedge clk);
        check({"R6 sclk idle ", tag}, {31'h0, spi_sclk}, {31'h0, setup[11]});
        bus_write(5'h10, 32'h0);
        bus_read(5'h10, d);
        check({"R8 cause cleared ", tag}, d, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 ss_n idle", {31'h0, spi_ss_n}, 32'h1);
        check("R1 sclk idle", {31'h0, spi_sclk}, 32'h0);
        bus_read(5'h00, d); check("R1 ctrl", d, 32'h0);
        bus_read(5'h04, d); check("R1 setup", d, 32'h0);
        bus_read(5'h0C, d); check("R1 rx", d, 32'h0);
        bus_read(5'h10, d); check("R1 cause", d, 32'h0);

        // R2 chip select
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_read(5'h00, d); check("R2 ctrl readback", d, 32'h1);
        check("R2 ss_n asserted", {31'h0, spi_ss_n}, 32'h0);

        // R3 unused setup bits
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_read(5'h04, d); check("R3 masked setup", d, 32'h0000_183F);

        // R4 R5 R6 R7 table walk over all modes, widths and divisors
        for (int i = 0; i < NVEC; i++)
            do_vec(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 0, $sformatf("v%0d", i));

        // R9 write during exchange ignored
        do_vec(16'h0014, 16'h00A6, 16'h0059, 1, "busy-write");
        // R10 setup change during exchange ignored
        do_vec(16'h0813, 16'h0096, 16'h0069, 2, "mid-setup");
        bus_read(5'h04, d); check("R10 new setup stored", d, 32'h0000_183F);

        // R8 nonzero write keeps flag
        bus_write(5'h04, 32'h0000_0012);
        b_bits = 8; b_cpha = 1'b0; rx_pat = 16'h0001;
        run_xfer(16'h0080, 0, cyc);
        bus_write(5'h10, 32'h0000_0005);
        bus_read(5'h10, d); check("R8 nonzero write keeps flag", d, 32'h1);
        bus_write(5'h10, 32'h0);
        bus_read(5'h10, d); check("R8 zero write clears", d, 32'h0);

        // R11 undefined offsets and transmit register read zero
        bus_read(5'h08, d); check("R11 tx reads zero", d, 32'h0);
        bus_read(5'h14, d); check("R11 offset 0x14", d, 32'h0);
        bus_read(5'h02, d); check("R11 offset 0x02", d, 32'h0);
        bus_read(5'h0C, d); check("R11 rx unchanged by reads", d, 32'h0000_0001);

        // R2 deassert
        bus_write(5'h00, 32'h0);
        check("R2 ss_n released", {31'h0, spi_ss_n}, 32'h1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule